// File: doc/BRIEF.md
# Serial Conversion-Result Output Port

This block sends a 16-bit conversion result to a host serial port, one bit per shift-clock period. The shift clock comes from a free-running divider of the system clock and is brought out so that the host can use it. A sample is first written into a holding register with a load strobe. An active-low frame-sync request from the host then copies the sample into the shift register, and the bits go out most significant first.

An active-low end-of-data strobe tells the host how the frame is progressing, and it depends on the framing mode latched at the frame start. In word mode the strobe is a single low pulse, one shift period long, right after the last bit. In byte mode the strobe stays low for the whole of the second byte, so the host can tell which byte it is receiving. An external flag marks a transfer as secondary (control traffic). The flag is latched with the frame, reported on an output, and keeps the strobe high for the whole transfer.

Top module: `sdo_serial_out`

## Requirements
- R1: The sample bits appear on `dout_o` most significant bit first, one bit per shift period. `dout_o` changes only at a shift-clock rising edge, so each bit is stable at the following falling edge.
- R2: `sclk_o` runs freely. It is low for HALF_DIV system clocks and then high for HALF_DIV system clocks. It starts low after reset.
- R3: A transfer starts when `fsync_n_i` is low at a system clock edge while `busy_o` is low. It sends the value most recently written with `load_i`. A load made during a transfer does not change that transfer, and it is the value sent by the next transfer.
- R4: Word mode (`byte_mode_i` = 0), primary transfer: `eod_n_o` falls at the shift rising edge that follows the 16th bit. It stays low for exactly one shift period and then returns high.
- R5: Byte mode (`byte_mode_i` = 1), primary transfer: `eod_n_o` falls at the rising edge that drives bit 7 (the first bit of the second byte). It stays low until the rising edge that follows the 16th bit.
- R6: When `secondary_i` is 1 at the frame start, `eod_n_o` stays high for the whole transfer. `busy_o` then clears at the rising edge after the 16th bit in both modes. `xfer_sec_o` shows the latched flag.
- R7: While `busy_o` is high, frame-sync requests are ignored, and changes on `byte_mode_i` and `secondary_i` have no effect on the transfer.
- R8: `busy_o` rises at the edge that captures the request. It falls at the rising edge that ends the strobe in a word-mode primary transfer, and at the rising edge after the 16th bit in every other case.
- R9: When idle, `dout_o` holds the last bit driven and `eod_n_o` is high.
- R10: A synchronous active-high `rst` sets `busy_o` to 0, `eod_n_o` to 1, `dout_o` to 0 and `xfer_sec_o` to 0, and abandons any transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_mode_i | input | 1 | Framing select: 0 word mode, 1 byte mode; latched at frame start |
| secondary_i | input | 1 | 1 marks the next transfer as secondary; latched at frame start |
| sample_i | input | DATA_W | Parallel conversion result |
| load_i | input | 1 | Writes sample_i into the holding register |
| fsync_n_i | input | 1 | Frame-sync request, active low |
| sclk_o | output | 1 | Shift clock |
| dout_o | output | 1 | Serial data, MSB first |
| eod_n_o | output | 1 | End-of-data strobe, active low |
| busy_o | output | 1 | High while a transfer and its strobe are in progress |
| xfer_sec_o | output | 1 | Latched secondary flag of the current or last transfer |

## Verification
The bench compares every shift rising edge against a queue of expected data, strobe and busy levels for each mode. This catches a strobe placed one period early or late, a byte-mode strobe that starts at the wrong bit, or a word pulse that lasts two periods. Secondary transfers in both modes show whether a design leaks a strobe or keeps busy high for an extra period. A second request, a new load and toggled mode inputs in the middle of a frame would show up as a corrupted bit stream in a design that does not latch at the frame start. A reset while the byte-mode strobe is low checks that the strobe is forced high.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
  localparam int unsigned SDO_DEF_DATA_W = 16;
  localparam int unsigned SDO_DEF_HALF_DIV = 4;

  typedef enum logic {
    FRAME_WORD = 1'b0,
    FRAME_BYTE = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/sdo_clkgen.sv
module sdo_clkgen #(
  parameter int unsigned HALF_DIV = sdo_pkg::SDO_DEF_HALF_DIV
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic rise_tick
);
  logic sclk_q;
  logic term;

  generate
    if (HALF_DIV <= 1) begin : g_nodiv
      assign term = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt_q;
      assign term = (cnt_q == CW'(HALF_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (term) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       sclk_q <= 1'b0;
    else if (term) sclk_q <= ~sclk_q;
  end

  assign rise_tick = term & ~sclk_q;
  assign sclk      = sclk_q;

  // R2: the shift clock is high after a rise tick and low after a fall
  a_r2_rise_sets_sclk: assert property (@(posedge clk) disable iff (rst)
    rise_tick |=> sclk_q);
  a_r2_fall_clears_sclk: assert property (@(posedge clk) disable iff (rst)
    (term && sclk_q) |=> !sclk_q);
endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter #(
  parameter int unsigned DATA_W = sdo_pkg::SDO_DEF_DATA_W,
  parameter int unsigned PH_W   = $clog2(DATA_W + 2) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              load_i,
  input  logic              fsync_n_i,
  input  logic              byte_mode_i,
  input  logic              secondary_i,
  input  logic              rise_tick,
  input  logic              done,
  output logic              busy,
  output logic [PH_W-1:0]   phase,
  output logic              byte_q,
  output logic              sec_q,
  output logic              dout
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sh_q;
  logic              busy_q;
  logic [PH_W-1:0]   ph_q;
  logic              byte_r;
  logic              sec_r;
  logic              dout_q;
  logic              start;

  assign start = !busy_q && !fsync_n_i;

  always_ff @(posedge clk) begin
    if (rst)         hold_q <= '0;
    else if (load_i) hold_q <= sample_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      sh_q   <= '0;
      byte_r <= 1'b0;
      sec_r  <= 1'b0;
      dout_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      ph_q   <= '0;
      sh_q   <= hold_q;
      byte_r <= byte_mode_i;
      sec_r  <= secondary_i;
    end else if (busy_q && rise_tick) begin
      if (done) busy_q <= 1'b0;
      ph_q <= ph_q + 1'b1;
      if (ph_q < PH_W'(DATA_W)) begin
        dout_q <= sh_q[DATA_W-1];
        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign busy   = busy_q;
  assign phase  = ph_q;
  assign byte_q = byte_r;
  assign sec_q  = sec_r;
  assign dout   = dout_q;

  // R7: the latched mode and secondary flag hold for the whole transfer
  a_r7_latch_stable: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (!busy_q || ($stable(sec_r) && $stable(byte_r))));
  // R8: the transfer never runs past the strobe phase
  a_r8_phase_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (ph_q <= PH_W'(DATA_W + 1)));
endmodule

// File: rtl/sdo_strobe.sv
module sdo_strobe #(
  parameter int unsigned DATA_W = sdo_pkg::SDO_DEF_DATA_W,
  parameter int unsigned PH_W   = $clog2(DATA_W + 2) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  logic            rise_tick,
  input  logic [PH_W-1:0] phase,
  input  logic            byte_q,
  input  logic            sec_q,
  output logic            done,
  output logic            eod_n
);
  import sdo_pkg::*;
  localparam int unsigned HALF_W = DATA_W / 2;

  frame_mode_e     mode;
  logic            eod_q;
  logic            eod_d;
  logic [PH_W-1:0] last_ph;

  assign mode = frame_mode_e'(byte_q);

  always_comb begin
    last_ph = (mode == FRAME_WORD && !sec_q) ? PH_W'(DATA_W + 1) : PH_W'(DATA_W);
    done    = busy && rise_tick && (phase == last_ph);
    eod_d   = eod_q;
    if (busy && rise_tick && !sec_q) begin
      if (mode == FRAME_BYTE) begin
        if (phase == PH_W'(HALF_W))      eod_d = 1'b0;
        else if (phase == PH_W'(DATA_W)) eod_d = 1'b1;
      end else begin
        if (phase == PH_W'(DATA_W))          eod_d = 1'b0;
        else if (phase == PH_W'(DATA_W + 1)) eod_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) eod_q <= 1'b1;
    else     eod_q <= eod_d;
  end

  assign eod_n = eod_q;

  // R6: no strobe during a secondary transfer
  a_r6_no_strobe_secondary: assert property (@(posedge clk) disable iff (rst)
    (busy && sec_q) |-> eod_q);
  // R9: the strobe is low only inside a transfer
  a_r9_strobe_idle_high: assert property (@(posedge clk) disable iff (rst)
    !eod_q |-> busy);
endmodule

// File: rtl/sdo_serial_out.sv
module sdo_serial_out #(
  parameter int unsigned DATA_W   = sdo_pkg::SDO_DEF_DATA_W,
  parameter int unsigned HALF_DIV = sdo_pkg::SDO_DEF_HALF_DIV
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode_i,
  input  logic              secondary_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              load_i,
  input  logic              fsync_n_i,
  output logic              sclk_o,
  output logic              dout_o,
  output logic              eod_n_o,
  output logic              busy_o,
  output logic              xfer_sec_o
);
  localparam int unsigned PH_W = $clog2(DATA_W + 2) + 1;

  logic            rise_tick;
  logic            done;
  logic            busy;
  logic [PH_W-1:0] phase;
  logic            byte_q;
  logic            sec_q;

  sdo_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .sclk(sclk_o), .rise_tick(rise_tick)
  );

  sdo_shifter #(.DATA_W(DATA_W), .PH_W(PH_W)) u_shift (
    .clk(clk), .rst(rst), .sample_i(sample_i), .load_i(load_i),
    .fsync_n_i(fsync_n_i), .byte_mode_i(byte_mode_i), .secondary_i(secondary_i),
    .rise_tick(rise_tick), .done(done), .busy(busy), .phase(phase),
    .byte_q(byte_q), .sec_q(sec_q), .dout(dout_o)
  );

  sdo_strobe #(.DATA_W(DATA_W), .PH_W(PH_W)) u_eod (
    .clk(clk), .rst(rst), .busy(busy), .rise_tick(rise_tick), .phase(phase),
    .byte_q(byte_q), .sec_q(sec_q), .done(done), .eod_n(eod_n_o)
  );

  assign busy_o     = busy;
  assign xfer_sec_o = sec_q;

  // R1: serial data moves only at a shift-clock rising edge
  a_r1_dout_on_rise: assert property (@(posedge clk) disable iff (rst)
    !rise_tick |=> $stable(dout_o));
  // R8: busy clears only at a shift-clock rising edge
  a_r8_busy_end_on_rise: assert property (@(posedge clk) disable iff (rst)
    (busy && !rise_tick) |=> busy);
endmodule

// File: tb/tb_sdo_serial_out.sv
module tb_sdo_serial_out;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_mode_i = 1'b0, secondary_i = 1'b0, load_i = 1'b0, fsync_n_i = 1'b1;
  logic [DW-1:0] sample_i = '0;
  logic sclk_o, dout_o, eod_n_o, busy_o, xfer_sec_o;

  always #2.5 clk = ~clk;

  sdo_serial_out #(.DATA_W(DW), .HALF_DIV(4)) dut (
    .clk(clk), .rst(rst), .byte_mode_i(byte_mode_i), .secondary_i(secondary_i),
    .sample_i(sample_i), .load_i(load_i), .fsync_n_i(fsync_n_i),
    .sclk_o(sclk_o), .dout_o(dout_o), .eod_n_o(eod_n_o), .busy_o(busy_o),
    .xfer_sec_o(xfer_sec_o)
  );

  typedef struct {
    logic  d;
    logic  e;
    logic  b;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic mon_sclk = 1'b0;
  logic mon_busy = 1'b0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: compares data, strobe and busy at each shift rising edge
  always @(negedge clk) begin
    if (rst) begin
      mon_sclk <= 1'b0;
      mon_busy <= 1'b0;
    end else begin
      if (!mon_sclk && sclk_o && mon_busy && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " dout/eod_n/busy"}, {{(DW-3){1'b0}}, dout_o, eod_n_o, busy_o},
              {{(DW-3){1'b0}}, e.d, e.e, e.b});
      end
      mon_sclk <= sclk_o;
      mon_busy <= busy_o;
    end
  end

  // driver side: expected stream built from R1, R4, R5, R6, R8
  task automatic push_stream(input logic [DW-1:0] s, input logic bm, input logic sec);
    exp_t e;
    for (int k = 1; k <= DW; k++) begin
      e.d = s[DW-k];
      e.b = 1'b1;
      e.e = (bm && !sec && k > DW/2) ? 1'b0 : 1'b1;
      e.tag = sec ? "R6" : (bm ? "R5" : "R1");
      exp_q.push_back(e);
    end
    e.d = s[0];
    if (!bm && !sec) begin
      e.e = 1'b0; e.b = 1'b1; e.tag = "R4";
      exp_q.push_back(e);
      e.e = 1'b1; e.b = 1'b0; e.tag = "R8";
      exp_q.push_back(e);
    end else begin
      e.e = 1'b1; e.b = 1'b0; e.tag = sec ? "R6" : "R5";
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_fall();
    logic ps;
    ps = sclk_o;
    forever begin
      @(negedge clk);
      if (ps && !sclk_o) break;
      ps = sclk_o;
    end
  endtask

  task automatic wait_rises(input int n);
    logic ps;
    int c;
    c = 0;
    ps = sclk_o;
    while (c < n) begin
      @(negedge clk);
      if (!ps && sclk_o) c++;
      ps = sclk_o;
    end
  endtask

  task automatic do_load(input logic [DW-1:0] s);
    @(negedge clk);
    sample_i = s;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic start_frame(input logic bm, input logic sec);
    wait_fall();
    byte_mode_i = bm;
    secondary_i = sec;
    fsync_n_i = 1'b0;
    @(negedge clk);
    fsync_n_i = 1'b1;
    check("R8 busy at start", {{(DW-1){1'b0}}, busy_o}, {{(DW-1){1'b0}}, 1'b1});
    check("R6 xfer_sec_o", {{(DW-1){1'b0}}, xfer_sec_o}, {{(DW-1){1'b0}}, sec});
  endtask

  task automatic finish_frame(input logic [DW-1:0] s);
    while (exp_q.size() > 0) @(negedge clk);
    repeat (12) @(negedge clk);
    check("R9 idle busy", {{(DW-1){1'b0}}, busy_o}, '0);
    check("R9 idle eod_n", {{(DW-1){1'b0}}, eod_n_o}, {{(DW-1){1'b0}}, 1'b1});
    check("R9 idle dout holds", {{(DW-1){1'b0}}, dout_o}, {{(DW-1){1'b0}}, s[0]});
  endtask

  task automatic run_xfer(input logic [DW-1:0] s, input logic bm, input logic sec);
    do_load(s);
    push_stream(s, bm, sec);
    start_frame(bm, sec);
    finish_frame(s);
  endtask

  task automatic check_sclk_period();
    int lo;
    int hi;
    lo = 0;
    hi = 0;
    wait_fall();
    while (!sclk_o) begin lo++; @(negedge clk); end
    while (sclk_o) begin hi++; @(negedge clk); end
    check("R2 sclk low length", DW'(lo), DW'(4));
    check("R2 sclk high length", DW'(hi), DW'(4));
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10 reset busy", {{(DW-1){1'b0}}, busy_o}, '0);
    check("R10 reset eod_n", {{(DW-1){1'b0}}, eod_n_o}, {{(DW-1){1'b0}}, 1'b1});
    check("R10 reset dout", {{(DW-1){1'b0}}, dout_o}, '0);
    check("R10 reset sec", {{(DW-1){1'b0}}, xfer_sec_o}, '0);
    check_sclk_period();

    run_xfer(16'hA5C3, 1'b0, 1'b0);
    run_xfer(16'h8001, 1'b0, 1'b0);
    run_xfer(16'hFFFF, 1'b0, 1'b0);
    run_xfer(16'h3C96, 1'b1, 1'b0);
    run_xfer(16'h7FFE, 1'b1, 1'b0);
    run_xfer(16'h1234, 1'b0, 1'b1);
    run_xfer(16'hCAFE, 1'b1, 1'b1);

    // R7 and R3: mid-frame request, load and mode changes are ignored
    do_load(16'h6B2D);
    push_stream(16'h6B2D, 1'b0, 1'b0);
    start_frame(1'b0, 1'b0);
    wait_rises(5);
    @(negedge clk);
    sample_i = 16'h0F0F;
    load_i = 1'b1;
    byte_mode_i = 1'b1;
    secondary_i = 1'b1;
    fsync_n_i = 1'b0;
    @(negedge clk);
    load_i = 1'b0;
    fsync_n_i = 1'b1;
    check("R7 xfer_sec_o unchanged", {{(DW-1){1'b0}}, xfer_sec_o}, '0);
    finish_frame(16'h6B2D);

    // R3: the load made during the frame is sent by the next one
    push_stream(16'h0F0F, 1'b0, 1'b0);
    start_frame(1'b0, 1'b0);
    finish_frame(16'h0F0F);

    // R10: reset while the byte-mode strobe is low
    do_load(16'h5555);
    start_frame(1'b1, 1'b0);
    wait_rises(11);
    @(negedge clk);
    check("R5 strobe low in second byte", {{(DW-1){1'b0}}, eod_n_o}, '0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 mid reset eod_n", {{(DW-1){1'b0}}, eod_n_o}, {{(DW-1){1'b0}}, 1'b1});
    check("R10 mid reset busy", {{(DW-1){1'b0}}, busy_o}, '0);
    check("R10 mid reset dout", {{(DW-1){1'b0}}, dout_o}, '0);
    repeat (40) @(negedge clk);
    check("R10 stays idle", {{(DW-1){1'b0}}, busy_o}, '0);
    check("R10 queue drained", DW'(exp_q.size()), '0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule